// File: doc/BRIEF.md
# Basic Block Successor Checker

This block runs beside a simple in-order pipeline and confirms that execution only moves from one basic block to a block that is allowed to follow it. Each block has an identity that comes from what the block contains, not from where it sits in memory. The block also carries, in spare bits of its own instructions, the identities of the blocks allowed to follow it. When a block begins, the pipeline passes both successor identities to the checker: one for the taken branch and one for the fall-through path. When the block ends, the pipeline reports which way the branch went and the signature of the block now being entered.

The checker picks the stored identity that matches the branch outcome and compares it with the entered signature. A mismatch produces a one-cycle error pulse, registered on the cycle after the end of the block. The checker runs alongside execution and has no way to stall the pipeline. A block with one successor carries that identity in both slots, so either outcome matches. No comparison takes place until a block start has loaded an expectation.

Top module: `cf_succ_checker`

## Requirements
- R1: An active-low asynchronous reset drives `flow_error` low and discards any held expectation, so a `blk_finish` right after reset raises no error.
- R2: On a cycle with `blk_begin` high, the checker stores `next_taken_sig` as the taken expectation and `next_fall_sig` as the fall-through expectation. Changes on those inputs while `blk_begin` is low have no effect.
- R3: On a `blk_finish` with `took_branch` = 1, `arrive_sig` is compared with the taken expectation.
- R4: On a `blk_finish` with `took_branch` = 0, `arrive_sig` is compared with the fall-through expectation.
- R5: A mismatch raises `flow_error` in the cycle after the `blk_finish` cycle, and only for that one cycle.
- R6: When `arrive_sig` equals the selected expectation, `flow_error` stays low.
- R7: A `blk_finish` that arrives before any `blk_begin` since reset is not compared.
- R8: A `blk_finish` uses up the expectation. A second `blk_finish` with no `blk_begin` in between is not compared.
- R9: When `blk_begin` and `blk_finish` are high in the same cycle, the comparison uses the expectations held before that cycle. The newly presented identities become the expectation for the next `blk_finish`.
- R10: A block with one successor, whose identity is presented in both slots, passes for either branch outcome.
- R11: `flow_error` is never high in a cycle that does not directly follow a `blk_finish` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_begin | input | 1 | First instruction of a basic block; load the successor identities |
| blk_finish | input | 1 | Block ends; branch outcome and entered signature are valid |
| took_branch | input | 1 | 1 = branch taken, 0 = fall-through |
| next_taken_sig | input | SIG_W | Identity of the successor on the taken path |
| next_fall_sig | input | SIG_W | Identity of the successor on the fall-through path |
| arrive_sig | input | SIG_W | Signature computed for the block being entered |
| flow_error | output | 1 | One-cycle pulse: the entered block was not the selected successor |

## Verification
The hardest case to reach from the ports is a block end that falls in the same cycle as the next block's start. In that cycle the old expectation must be used for the comparison while the new one is loaded. The bench drives both strobes together. It presents an entered signature that matches only the old identity, and another that matches only the new one. It then ends the following block against the newly loaded pair. Beyond that, a sweep over every combination of taken identity, fall identity, entered signature and outcome, at a narrow width, covers each selection and comparison case.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int CFC_NUM_SLOTS = 2;

  typedef enum logic {
    SLOT_FALL  = 1'b0,
    SLOT_TAKEN = 1'b1
  } cfc_slot_e;

  // Maps the resolved branch outcome to the slot holding its expectation.
  function automatic cfc_slot_e slot_for_outcome(input logic taken);
    return taken ? SLOT_TAKEN : SLOT_FALL;
  endfunction
endpackage

// File: rtl/cfc_slot_store.sv
module cfc_slot_store
  import cfc_pkg::*;
#(
  parameter int SIG_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load,
  input  logic [CFC_NUM_SLOTS-1:0][SIG_W-1:0]  slot_d,
  output logic [CFC_NUM_SLOTS-1:0][SIG_W-1:0]  slot_q
);
  for (genvar s = 0; s < CFC_NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (load) begin
        slot_q[s] <= slot_d[s];
      end
    end
  end
endmodule

// File: rtl/cfc_arm_tracker.sv
module cfc_arm_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_begin,
  input  logic blk_finish,
  output logic armed_q
);
  // Armed by a block start; a block end consumes it unless a new start coincides.
  function automatic logic next_armed(input logic armed, input logic bgn, input logic fin);
    return bgn | (armed & ~fin);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= next_armed(armed_q, blk_begin, blk_finish);
  end
endmodule

// File: rtl/cfc_select_cmp.sv
module cfc_select_cmp
  import cfc_pkg::*;
#(
  parameter int SIG_W = 16
) (
  input  logic [CFC_NUM_SLOTS-1:0][SIG_W-1:0] slot_q,
  input  logic                                took_branch,
  input  logic [SIG_W-1:0]                    arrive_sig,
  output logic [SIG_W-1:0]                    expected_sig,
  output logic                                sig_differs
);
  function automatic logic differs(input logic [SIG_W-1:0] a, input logic [SIG_W-1:0] b);
    return |(a ^ b);
  endfunction

  always_comb begin
    expected_sig = slot_q[slot_for_outcome(took_branch)];
    sig_differs  = differs(expected_sig, arrive_sig);
  end
endmodule

// File: rtl/cfc_flag.sv
module cfc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic check_fire,
  input  logic sig_differs,
  output logic flow_error
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flow_error <= 1'b0;
    else        flow_error <= check_fire & sig_differs;
  end
endmodule

// File: rtl/cf_succ_checker.sv
module cf_succ_checker
  import cfc_pkg::*;
#(
  parameter int SIG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_begin,
  input  logic             blk_finish,
  input  logic             took_branch,
  input  logic [SIG_W-1:0] next_taken_sig,
  input  logic [SIG_W-1:0] next_fall_sig,
  input  logic [SIG_W-1:0] arrive_sig,
  output logic             flow_error
);
  // Internal events, named so the checker module can observe them.
  logic [CFC_NUM_SLOTS-1:0][SIG_W-1:0] slot_d;
  logic [CFC_NUM_SLOTS-1:0][SIG_W-1:0] slots_q;
  logic                                armed_q;
  logic [SIG_W-1:0]                    expected_sig;
  logic                                sig_differs;
  logic                                check_fire;

  always_comb begin
    slot_d[SLOT_TAKEN] = next_taken_sig;
    slot_d[SLOT_FALL]  = next_fall_sig;
  end

  assign check_fire = blk_finish & armed_q;

  cfc_slot_store #(.SIG_W(SIG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (blk_begin),
    .slot_d (slot_d),
    .slot_q (slots_q)
  );

  cfc_arm_tracker u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_begin  (blk_begin),
    .blk_finish (blk_finish),
    .armed_q    (armed_q)
  );

  cfc_select_cmp #(.SIG_W(SIG_W)) u_cmp (
    .slot_q       (slots_q),
    .took_branch  (took_branch),
    .arrive_sig   (arrive_sig),
    .expected_sig (expected_sig),
    .sig_differs  (sig_differs)
  );

  cfc_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .check_fire  (check_fire),
    .sig_differs (sig_differs),
    .flow_error  (flow_error)
  );
endmodule

// File: rtl/cfc_props.sv
module cfc_props
  import cfc_pkg::*;
#(
  parameter int SIG_W = 16
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                blk_begin,
  input logic                                blk_finish,
  input logic                                took_branch,
  input logic [SIG_W-1:0]                    next_taken_sig,
  input logic [SIG_W-1:0]                    next_fall_sig,
  input logic [SIG_W-1:0]                    arrive_sig,
  input logic                                flow_error,
  input logic                                armed_q,
  input logic [CFC_NUM_SLOTS-1:0][SIG_W-1:0] slots_q
);
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_begin |=> (slots_q[SLOT_TAKEN] == $past(next_taken_sig)) &&
                  (slots_q[SLOT_FALL]  == $past(next_fall_sig)));

  assert_taken_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_finish && armed_q && took_branch && (arrive_sig != slots_q[SLOT_TAKEN])) |=> flow_error);

  assert_fall_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_finish && armed_q && !took_branch && (arrive_sig != slots_q[SLOT_FALL])) |=> flow_error);

  assert_match_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_finish && armed_q &&
     (arrive_sig == (took_branch ? slots_q[SLOT_TAKEN] : slots_q[SLOT_FALL]))) |=> !flow_error);

  assert_unarmed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_finish && !armed_q) |=> !flow_error);

  assert_consume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_finish && !blk_begin) |=> !armed_q);

  assert_only_after_finish_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_finish |=> !flow_error);
endmodule

bind cf_succ_checker cfc_props #(.SIG_W(SIG_W)) u_props (
  .clk            (clk),
  .rst_n          (rst_n),
  .blk_begin      (blk_begin),
  .blk_finish     (blk_finish),
  .took_branch    (took_branch),
  .next_taken_sig (next_taken_sig),
  .next_fall_sig  (next_fall_sig),
  .arrive_sig     (arrive_sig),
  .flow_error     (flow_error),
  .armed_q        (armed_q),
  .slots_q        (slots_q)
);

// File: tb/test_cf_succ_checker.sv
module test_cf_succ_checker;
  localparam int W = 4;
  localparam int NV = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         blk_begin = 1'b0;
  logic         blk_finish = 1'b0;
  logic         took_branch = 1'b0;
  logic [W-1:0] next_taken_sig = '0;
  logic [W-1:0] next_fall_sig = '0;
  logic [W-1:0] arrive_sig = '0;
  logic         flow_error;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  cf_succ_checker #(.SIG_W(W)) i_cf_succ_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .blk_begin      (blk_begin),
    .blk_finish     (blk_finish),
    .took_branch    (took_branch),
    .next_taken_sig (next_taken_sig),
    .next_fall_sig  (next_fall_sig),
    .arrive_sig     (arrive_sig),
    .flow_error     (flow_error)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flow_error actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Inputs change and outputs are sampled at the falling edge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive_begin(input logic [W-1:0] t, input logic [W-1:0] f);
    blk_begin = 1'b1; next_taken_sig = t; next_fall_sig = f;
  endtask

  task automatic drive_finish(input logic tk, input logic [W-1:0] a);
    blk_finish = 1'b1; took_branch = tk; arrive_sig = a;
  endtask

  task automatic idle();
    blk_begin = 1'b0; blk_finish = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    step(); step();
    chk("R1 reset low", flow_error, 1'b0);
    rst_n = 1'b1;
    step();

    // R7: finish before any begin, signature differs from reset slots
    drive_finish(1'b1, 4'hA);
    step(); idle();
    chk("R7 no compare before first begin", flow_error, 1'b0);

    // R5, R3: mismatch pulse lasts one cycle
    step(); drive_begin(4'h1, 4'h2);
    step(); blk_begin = 1'b0; drive_finish(1'b1, 4'h7);
    step(); idle();
    chk("R5 pulse after mismatch", flow_error, 1'b1);
    step();
    chk("R5 pulse width one cycle", flow_error, 1'b0);

    // R8: finish consumes expectation
    drive_begin(4'h3, 4'h5);
    step(); blk_begin = 1'b0; drive_finish(1'b1, 4'h3);
    step(); drive_finish(1'b0, 4'h9);
    chk("R6 match quiet", flow_error, 1'b0);
    step(); idle();
    chk("R8 second finish not compared", flow_error, 1'b0);

    // R9: same-cycle begin+finish compares against old pair
    step(); drive_begin(4'h1, 4'h2);
    step(); drive_begin(4'h6, 4'h8); drive_finish(1'b1, 4'h1);
    step(); blk_begin = 1'b0; drive_finish(1'b0, 4'h9);
    chk("R9 overlap uses old taken id", flow_error, 1'b0);
    step(); idle();
    chk("R9 new fall id loaded (9 vs 8)", flow_error, 1'b1);
    step(); drive_begin(4'h1, 4'h2);
    step(); drive_begin(4'h6, 4'h8); drive_finish(1'b1, 4'h6);
    step(); blk_begin = 1'b0; drive_finish(1'b1, 4'h6);
    chk("R9 overlap ignores new id for compare", flow_error, 1'b1);
    step(); idle();
    chk("R9 new taken id matches", flow_error, 1'b0);

    // R10: single successor in both slots
    for (int o = 0; o < 2; o++) begin
      step(); drive_begin(4'h4, 4'h4);
      step(); blk_begin = 1'b0; drive_finish(o[0], 4'h4);
      step(); idle();
      chk("R10 single successor either outcome", flow_error, 1'b0);
    end

    // R2: successor inputs ignored while blk_begin is low
    step(); drive_begin(4'h5, 4'h6);
    step(); blk_begin = 1'b0; next_taken_sig = 4'hE; next_fall_sig = 4'hD;
    step(); drive_finish(1'b1, 4'h5);
    step(); idle();
    chk("R2 taken slot unchanged without begin", flow_error, 1'b0);

    // R1: reset mid-flight discards expectation
    step(); drive_begin(4'h2, 4'h3);
    step(); idle(); rst_n = 1'b0;
    step(); rst_n = 1'b1;
    step(); drive_finish(1'b1, 4'hF);
    step(); idle();
    chk("R1 reset discards expectation", flow_error, 1'b0);

    // Sweep: every taken id, fall id, arrival and outcome (R3, R4, R6, R11)
    step();
    for (int t = 0; t < NV; t++) begin
      for (int f = 0; f < NV; f++) begin
        for (int a = 0; a < NV; a++) begin
          for (int o = 0; o < 2; o++) begin
            logic exp_err;
            exp_err = (o == 1) ? (a != t) : (a != f);
            drive_begin(t[W-1:0], f[W-1:0]);
            step(); blk_begin = 1'b0; drive_finish(o[0], a[W-1:0]);
            chk("R11 quiet after a begin-only cycle", flow_error, 1'b0);
            step(); blk_finish = 1'b0;
            if (o == 1) chk("R3 taken compare", flow_error, exp_err);
            else        chk("R4 fall compare", flow_error, exp_err);
          end
        end
      end
    end
    step();
    chk("R11 quiet at idle", flow_error, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule